// File: doc/BRIEF.md
# Seconds Clock with Dual Alarms and Rate Trim

The block keeps wall time as a 32-bit count of seconds. A strobe at 32768 Hz (one clock-wide pulse per oscillator period) drives a binary prescaler. Each wrap of the prescaler steps the seconds count. Two alarm channels compare their own 32-bit seconds value against the count. On a match each channel raises a status flag, and it can also drive the shared interrupt. Each channel can also emit a periodic event pulse. The pulse rate is either once per second or a fixed fraction of a second. Software reaches everything through a single-cycle register port. Writes take effect at the clock edge and reads are combinational from the word address.

Rate trimming is handled by a calibration state machine. It counts raw strobes in a fixed window of 2^WIN_LOG2 strobes. At each window boundary it loads a tick budget equal to the magnitude of the signed 8-bit offset. In coarse mode the budget is four times that magnitude. The states are CAL_IDLE (budget zero, strobes pass through), CAL_ADJ (budget remaining) and CAL_PASS (budget used up, strobes pass through until the window ends). The transitions are:
- From any state, a window end goes to CAL_ADJ if the new budget is nonzero, and to CAL_IDLE otherwise.
- From CAL_ADJ, the strobe that spends the last budget unit goes to CAL_PASS.

In CAL_ADJ a positive offset makes each strobe advance the prescaler by two. A negative offset makes each strobe advance it by zero. With the default window of 2^20 strobes, one fine step is one strobe per window, about 954 ppb. One coarse step is four strobes, about 3815 ppb. The correction register only accepts a value whose bits 14:8 carry a fixed pattern derived from the sign bit.

Top module: `rtc_secs_core`

## Requirements
- R1: After reset these registers read as follows: status (word 0x00) reads 0, seconds (0x0C) reads 0, both alarms (0x10, 0x14) read 0, both channel configs (0x04, 0x08) read 0, and correction (0x18) reads 0x00002000 (zero offset, fine mode). The irq output is low.
- R2: With zero correction, every 2^TICK_LOG2 strobes step the seconds count by exactly one. A write to 0x0C loads the count and clears the prescaler, so the next step comes a full 2^TICK_LOG2 strobes later.
- R3: Status bit 0 (alarm 1, value at 0x10) sets when the seconds count and the alarm value become equal. Status bit 1 does the same for alarm 2 (value at 0x14). This happens whether or not the alarm is enabled, and it also happens when the alarm value is written to equal the current count.
- R4: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R5: irq is high exactly while some status bit is set and bit 0 (alarm enable) of that channel's config register is set. Config bits 1 and 2 have no effect on irq.
- R6: When config bit 1 is set, a channel pulses its per_evt bit for one cycle. If config bit 2 is 1, the pulse comes on every seconds step. If bit 2 is 0, it comes every 2^(TICK_LOG2-SUB_LOG2) prescaler counts.
- R7: A write to 0x18 is stored only when bits 14:8 equal {0, ~S, S, S, S, S, S}, where S is bit 7. Any other write is ignored. Bits 15:0 are stored and bits 31:16 read 0.
- R8: The correction register has a signed offset in bits 7:0 and a coarse select in bit 15. It is applied from the next window boundary. In each window, the first |offset| strobes (or 4*|offset| in coarse mode) advance the prescaler by 2 when the offset is positive and by 0 when it is negative. All other strobes advance it by 1.
- R9: The test register (0x1C) stores bits 7:0 and reads 0x000000FF after reset, a nonzero value that marks the clock as uninitialised. Writing 0 there makes it read 0.
- R10: Each config register reads back only bits 2:0, and the status register reads back only bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle strobe per oscillator period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Alarm interrupt |
| per_evt | output | 2 | Periodic event pulse per channel |

## Verification
The assertions check the following on every cycle:
- The seconds count only holds or steps by one unless software writes it.
- The stored correction always carries a legal sign pattern.
- The calibration budget never grows inside a window and is empty in CAL_IDLE and CAL_PASS.
- An alarm flag sets after an equality edge and clears after an acknowledge.
- A once-per-second event coincides with a seconds step.

Only the bench scenarios can show the rest:
- The exact count reached after a trimmed window in fine and coarse mode, with positive and negative offsets.
- That a correction write waits for the window boundary.
- The pulse counts of the two periodic rates.
- The interaction of enable bits with irq.
- That illegal correction writes and writes of zero to status leave the state untouched.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_STAT = 3'd0;
    localparam logic [IDX_W-1:0] IDX_CFG1 = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CFG2 = 3'd2;
    localparam logic [IDX_W-1:0] IDX_TIME = 3'd3;
    localparam logic [IDX_W-1:0] IDX_ALM1 = 3'd4;
    localparam logic [IDX_W-1:0] IDX_ALM2 = 3'd5;
    localparam logic [IDX_W-1:0] IDX_CORR = 3'd6;
    localparam logic [IDX_W-1:0] IDX_TEST = 3'd7;

    localparam logic [15:0] CORR_NOMINAL = 16'h2000;
    localparam logic [7:0]  TEST_UNINIT  = 8'hFF;

    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_ADJ  = 2'd1,
        CAL_PASS = 2'd2
    } cal_state_t;

    function automatic logic corr_word_legal(input logic [15:0] v);
        return v[14:8] == {1'b0, ~v[7], {5{v[7]}}};
    endfunction
endpackage

// File: rtl/rtc_cal_fsm.sv
module rtc_cal_fsm
    import rtc_pkg::*;
#(
    parameter int WIN_LOG2 = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] corr_off,
    input  logic       corr_coarse,
    output logic [1:0] adv
);
    localparam int BUD_W = 11;

    cal_state_t state, nxt;
    logic [WIN_LOG2-1:0] win_cnt;
    logic [BUD_W-1:0]    budget;
    logic [BUD_W-1:0]    load;
    logic [8:0]          mag;
    logic                dir_pos;
    logic                win_end;

    assign win_end = tick && (&win_cnt);

    always_comb begin
        mag  = corr_off[7] ? (9'd0 - {1'b1, corr_off}) : {1'b0, corr_off};
        load = corr_coarse ? {mag, 2'b00} : {2'b00, mag};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAL_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (win_end) begin
            nxt = (load != '0) ? CAL_ADJ : CAL_IDLE;
        end else begin
            unique case (state)
                CAL_IDLE: nxt = CAL_IDLE;
                CAL_ADJ:  if (tick && budget == BUD_W'(1)) nxt = CAL_PASS;
                CAL_PASS: nxt = CAL_PASS;
                default:  nxt = CAL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
            budget  <= '0;
            dir_pos <= 1'b1;
        end else begin
            if (tick) win_cnt <= win_cnt + 1'b1;
            if (win_end) begin
                budget  <= load;
                dir_pos <= !corr_off[7];
            end else if (state == CAL_ADJ && tick) begin
                budget <= budget - 1'b1;
            end
        end
    end

    always_comb begin
        adv = 2'd0;
        if (tick) begin
            unique case (state)
                CAL_ADJ:  adv = dir_pos ? 2'd2 : 2'd0;
                CAL_IDLE: adv = 2'd1;
                CAL_PASS: adv = 2'd1;
                default:  adv = 2'd1;
            endcase
        end
    end

    // R8: budget only shrinks inside a window
    assert_budget_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_end) |=> (budget <= $past(budget)));

    // R8: no remaining budget while strobes pass unchanged
    assert_budget_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAL_IDLE || state == CAL_PASS) |-> (budget == '0));
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICK_LOG2 = 15,
    parameter int SUB_LOG2  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] adv,
    input  logic       clr,
    output logic       sec_step,
    output logic       sub_step
);
    localparam int TOP = TICK_LOG2 - 1;

    logic [TICK_LOG2-1:0] pre_q;
    logic [TICK_LOG2:0]   sum;

    assign sum = {1'b0, pre_q} + {{(TICK_LOG2-1){1'b0}}, adv};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pre_q <= '0;
        else if (clr) pre_q <= '0;
        else          pre_q <= sum[TICK_LOG2-1:0];
    end

    always_comb begin
        sec_step = !clr && sum[TICK_LOG2];
        sub_step = !clr && (sec_step ||
                   (sum[TOP -: SUB_LOG2] != pre_q[TOP -: SUB_LOG2]));
    end
endmodule

// File: rtl/rtc_alarm_ch.sv
module rtc_alarm_ch (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] time_q,
    input  logic        wr_alm,
    input  logic        wr_cfg,
    input  logic [31:0] wdata,
    input  logic        ack,
    input  logic        sec_step,
    input  logic        sub_step,
    output logic [31:0] alarm_q,
    output logic [2:0]  cfg_q,
    output logic        flag,
    output logic        irq_req,
    output logic        per_evt
);
    logic match, match_d, hit;

    assign match = (time_q == alarm_q);
    assign hit   = match && !match_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= '0;
            cfg_q   <= '0;
            match_d <= 1'b1;
            flag    <= 1'b0;
            per_evt <= 1'b0;
        end else begin
            if (wr_alm) alarm_q <= wdata;
            if (wr_cfg) cfg_q   <= wdata[2:0];
            match_d <= match;
            flag    <= hit || (flag && !ack);
            per_evt <= cfg_q[1] && (cfg_q[2] ? sec_step : sub_step);
        end
    end

    assign irq_req = flag && cfg_q[0];

    // R3: equality edge raises the flag
    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R4: acknowledge clears the flag when no new hit arrives
    assert_flag_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !flag);
endmodule

// File: rtl/rtc_secs_core.sv
module rtc_secs_core
    import rtc_pkg::*;
#(
    parameter int TICK_LOG2 = 15,
    parameter int SUB_LOG2  = 2,
    parameter int WIN_LOG2  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_32k,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic [1:0]  per_evt
);
    localparam int NCH = 2;

    logic [IDX_W-1:0] idx;
    logic [31:0]      time_q;
    logic [15:0]      corr_q;
    logic [7:0]       test_q;
    logic [1:0]       adv;
    logic             sec_step, sub_step;
    logic             wr_time, wr_corr, wr_test;
    logic [1:0]       ack;

    logic [31:0] alarm_q [NCH];
    logic [2:0]  cfg_q   [NCH];
    logic [NCH-1:0] flag, irq_req;

    assign idx     = bus_addr[4:2];
    assign wr_time = bus_wr && idx == IDX_TIME;
    assign wr_corr = bus_wr && idx == IDX_CORR;
    assign wr_test = bus_wr && idx == IDX_TEST;
    assign ack     = (bus_wr && idx == IDX_STAT) ? bus_wdata[1:0] : 2'b00;

    rtc_cal_fsm #(.WIN_LOG2(WIN_LOG2)) u_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_32k),
        .corr_off   (corr_q[7:0]),
        .corr_coarse(corr_q[15]),
        .adv        (adv)
    );

    rtc_prescaler #(.TICK_LOG2(TICK_LOG2), .SUB_LOG2(SUB_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .clr     (wr_time),
        .sec_step(sec_step),
        .sub_step(sub_step)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        rtc_alarm_ch u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .time_q  (time_q),
            .wr_alm  (bus_wr && idx == IDX_ALM1 + IDX_W'(i)),
            .wr_cfg  (bus_wr && idx == IDX_CFG1 + IDX_W'(i)),
            .wdata   (bus_wdata),
            .ack     (ack[i]),
            .sec_step(sec_step),
            .sub_step(sub_step),
            .alarm_q (alarm_q[i]),
            .cfg_q   (cfg_q[i]),
            .flag    (flag[i]),
            .irq_req (irq_req[i]),
            .per_evt (per_evt[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
            corr_q <= CORR_NOMINAL;
            test_q <= TEST_UNINIT;
        end else begin
            if (wr_time)       time_q <= bus_wdata;
            else if (sec_step) time_q <= time_q + 32'd1;
            if (wr_corr && corr_word_legal(bus_wdata[15:0])) corr_q <= bus_wdata[15:0];
            if (wr_test) test_q <= bus_wdata[7:0];
        end
    end

    assign irq = |irq_req;

    always_comb begin
        unique case (idx)
            IDX_STAT: bus_rdata = {30'd0, flag};
            IDX_CFG1: bus_rdata = {29'd0, cfg_q[0]};
            IDX_CFG2: bus_rdata = {29'd0, cfg_q[1]};
            IDX_TIME: bus_rdata = time_q;
            IDX_ALM1: bus_rdata = alarm_q[0];
            IDX_ALM2: bus_rdata = alarm_q[1];
            IDX_CORR: bus_rdata = {16'd0, corr_q};
            IDX_TEST: bus_rdata = {24'd0, test_q};
            default:  bus_rdata = '0;
        endcase
    end

    // R2: count holds or steps by one unless written
    assert_time_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_time) |=> (time_q == $past(time_q) || time_q == $past(time_q) + 32'd1));

    // R7: stored correction always carries a legal sign pattern
    assert_corr_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        corr_q[14:8] == {1'b0, ~corr_q[7], {5{corr_q[7]}}});

    // R6: once-per-second event coincides with a seconds step
    assert_sec_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (per_evt[0] && $past(cfg_q[0][2]) && !$past(wr_time)) |-> (time_q == $past(time_q) + 32'd1));
endmodule

// File: tb/sim_rtc_secs_core.sv
module sim_rtc_secs_core;
    localparam int TL = 3;
    localparam int SL = 1;
    localparam int WL = 5;
    localparam int TPS = 1 << TL;
    localparam int WIN = 1 << WL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_32k = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [1:0]  per_evt;

    always #5 clk = ~clk;

    rtc_secs_core #(.TICK_LOG2(TL), .SUB_LOG2(SL), .WIN_LOG2(WL)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .per_evt(per_evt)
    );

    typedef struct {
        int          kind;
        logic [4:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    vectors = 0;
    int    miscompares = 0;
    logic  probe = 1'b0;
    int    cnt0 = 0, cnt1 = 0, base0 = 0, base1 = 0;
    bit    done = 1'b0;

    int m_pre = 0, m_win = 0, m_budget = 0;
    bit m_pos = 1'b1;
    logic [31:0] m_time = 0;
    logic [15:0] m_corr = 16'h2000;

    always @(negedge clk) begin
        if (per_evt[0]) cnt0++;
        if (per_evt[1]) cnt1++;
    end

    always @(negedge clk) begin
        if (probe && q.size() > 0) begin
            item_t it;
            logic [31:0] obs;
            it = q.pop_front();
            case (it.kind)
                0: obs = bus_rdata;
                1: obs = {31'd0, irq};
                2: obs = 32'(cnt0 - base0);
                default: obs = 32'(cnt1 - base1);
            endcase
            vectors++;
            if (obs !== it.exp) begin
                miscompares++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic expect_item(input int kind, input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        bus_addr = a;
        probe = 1'b1;
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic chk_reg(input logic [4:0] a, input logic [31:0] e, input string tag);
        expect_item(0, a, e, tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        if (a == 5'h0C) begin m_time = d; m_pre = 0; end
        if (a == 5'h18 && d[14:8] == {1'b0, ~d[7], {5{d[7]}}}) m_corr = d[15:0];
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            int adv;
            int mag;
            tick_32k = 1'b1;
            @(posedge clk); #1;
            tick_32k = 1'b0;
            adv = 1;
            if (m_budget > 0) begin
                adv = m_pos ? 2 : 0;
                m_budget--;
            end
            m_pre += adv;
            if (m_pre >= TPS) begin m_pre -= TPS; m_time++; end
            m_win++;
            if (m_win == WIN) begin
                m_win = 0;
                mag = m_corr[7] ? 256 - int'(m_corr[7:0]) : int'(m_corr[7:0]);
                m_budget = m_corr[15] ? mag * 4 : mag;
                m_pos = !m_corr[7];
            end
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got 0x00000000 expected 0x00000001");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        chk_reg(5'h00, 32'h0, "R1 status reset");
        chk_reg(5'h0C, 32'h0, "R1 seconds reset");
        chk_reg(5'h10, 32'h0, "R1 alarm1 reset");
        chk_reg(5'h08, 32'h0, "R1 cfg2 reset");
        chk_reg(5'h18, 32'h2000, "R1 correction reset");
        expect_item(1, 5'h00, 32'h0, "R1 irq reset");
        chk_reg(5'h1C, 32'hFF, "R9 test reset uninit");

        wr(5'h1C, 32'h0);
        chk_reg(5'h1C, 32'h0, "R9 test cleared");
        wr(5'h1C, 32'h1234);
        chk_reg(5'h1C, 32'h34, "R9 test low byte");

        ticks(2 * TPS);
        chk_reg(5'h0C, 32'd2, "R2 two seconds");
        ticks(TPS / 2);
        wr(5'h0C, 32'd100);
        ticks(TPS - 1);
        chk_reg(5'h0C, 32'd100, "R2 write clears prescaler");
        ticks(1);
        chk_reg(5'h0C, 32'd101, "R2 full second after write");
        wr(5'h0C, 32'd100);

        wr(5'h10, 32'd102);
        wr(5'h14, 32'd200);
        wr(5'h04, 32'd6);
        wr(5'h08, 32'd2);
        base0 = cnt0; base1 = cnt1;
        ticks(2 * TPS);
        expect_item(2, 5'h00, 32'd2, "R6 per-second pulses");
        expect_item(3, 5'h00, 32'd4, "R6 sub-second pulses");
        chk_reg(5'h00, 32'h1, "R3 alarm1 flag at match");
        expect_item(1, 5'h00, 32'h0, "R5 irq low with enable clear");

        wr(5'h04, 32'd1);
        expect_item(1, 5'h00, 32'h1, "R5 irq with enable");
        chk_reg(5'h04, 32'h1, "R10 cfg1 readback");
        wr(5'h08, 32'hFFFF_FFFF);
        chk_reg(5'h08, 32'h7, "R10 cfg2 masked");
        wr(5'h08, 32'h0);

        wr(5'h00, 32'hFFFF_FFFC);
        chk_reg(5'h00, 32'h1, "R4 write zero keeps flag");
        wr(5'h00, 32'h1);
        chk_reg(5'h00, 32'h0, "R4 write one clears");
        expect_item(1, 5'h00, 32'h0, "R5 irq after ack");

        wr(5'h14, 32'd102);
        @(posedge clk); #1;
        chk_reg(5'h00, 32'h2, "R3 alarm2 set by value write");
        expect_item(1, 5'h00, 32'h0, "R5 irq ignores disabled flag");
        wr(5'h08, 32'h1);
        expect_item(1, 5'h00, 32'h1, "R5 irq channel 2");
        wr(5'h00, 32'h2);
        chk_reg(5'h00, 32'h0, "R4 ack alarm2");
        wr(5'h08, 32'h0);
        wr(5'h04, 32'h0);

        wr(5'h18, 32'h0000_0003);
        chk_reg(5'h18, 32'h2000, "R7 illegal pattern ignored");
        wr(5'h18, 32'hFFFF_2003);
        chk_reg(5'h18, 32'h2003, "R7 legal write stored");

        wr(5'h0C, 32'd0);
        while (m_win != 0) ticks(1);
        chk_reg(5'h0C, m_time, "R8 reach boundary");
        ticks(WIN);
        chk_reg(5'h0C, m_time, "R8 fine positive window");
        wr(5'h18, 32'h0000_9FFF);
        ticks(WIN);
        chk_reg(5'h0C, m_time, "R8 deferred to boundary");
        ticks(WIN);
        chk_reg(5'h0C, m_time, "R8 coarse negative window");
        wr(5'h18, 32'h0000_1FFE);
        ticks(2 * WIN + 5);
        chk_reg(5'h0C, m_time, "R8 fine negative window");

        @(posedge clk); #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule